// File: doc/BRIEF.md
# Iterative Subtract-While-Greater Unit

This unit repeatedly subtracts an unsigned divisor-like operand `b` from a working value `a` for as long as `a` is strictly greater than `b`. It then reports the value of `a` that remains. The datapath has exactly one adder. In alternating cycles that adder first decides whether `a > b` and then forms `a - b`. Subtraction is done as `a + ~b + 1`. The unsigned comparison is read from the adder's carry-out, so operands with the top bit set compare correctly.

An input multiplexer feeds the working register. It selects the externally supplied operand when the job is accepted, and the adder's difference after each subtract step. When the comparison fails, a demultiplexed load path copies the working value into the result register. A one-cycle `done` pulse follows. A `start` pulse while the unit is idle begins a job. A `start` pulse while a job runs is ignored. If `b` is zero, the unit stops after its first comparison and returns `a` unchanged.

Top module: `subgt_loop`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `result` is 0.
- R2: For `b` nonzero, `result` equals the value left by the loop "while (a > b) a = a - b". This value is never greater than `b`. When `b` divides `a` exactly and `a > b`, the value is `b`, not 0.
- R3: Equality counts as not greater. If `a <= b`, no subtraction takes place and `result` equals `a`.
- R4: If `b` is 0, the job ends after a single comparison with `result` equal to `a`.
- R5: The start cycle is the cycle in which `start` is sampled high while idle. If a job performs k subtractions, `done` is high in the cycle that begins 2k+1 rising edges after the start cycle's edge. `busy` is 1 in every cycle from the one after the start cycle up to, but not including, the `done` cycle.
- R6: `done` is high for exactly one cycle. `result` changes only together with a `done` pulse, and it holds its value until the next job completes.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored. Its operands have no effect on the running job's `result` or its timing.
- R8: The comparison is a full-range unsigned comparison. Operands at or above 2^(W-1) give the same results as the unsigned loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job when idle |
| a_in | input | W | Initial working value |
| b_in | input | W | Value subtracted on each pass |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Final value of the loop |

## Verification
Directed cases try the boundaries of the loop:
- `a == b` and `a < b` separate the strict comparison from greater-or-equal.
- `b == 0` shows the exit that prevents an endless loop.
- `a` a multiple of `b` tells a "stop at b" loop apart from a plain remainder.
- Operands with the top bit set tell a carry-based comparison apart from one that uses the sign bit.
- `a = 2^W-1` with `b = 1` gives the longest run.

Random operands at a fixed seed check the result value and the exact 2k+1 latency, and each run also confirms the single-cycle `done` pulse. A second `start` injected in the middle of a job shows that operands supplied while busy are ignored.

// File: rtl/subgt_loop.sv
module subgt_loop #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_SUB} state_t;

  state_t       state;
  logic [W-1:0] a_q, b_q, fin_q;
  logic         done_q;

  // single adder: a + ~b + 1
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         is_neg, go_on, sel_fb, ld_fin;
  logic [W-1:0] a_mux;

  assign sum    = {1'b0, a_q} + {1'b0, ~b_q} + {{W{1'b0}}, 1'b1};
  assign diff   = sum[W-1:0];
  assign is_neg = sum[W] ^ 1'b1;
  assign go_on  = !is_neg && (diff != '0) && (b_q != '0);
  assign sel_fb = (state == S_SUB);
  assign a_mux  = sel_fb ? diff : a_in;
  assign ld_fin = (state == S_CMP) && !go_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      fin_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= ld_fin;
      unique case (state)
        S_IDLE: if (start) begin
          a_q   <= a_mux;
          b_q   <= b_in;
          state <= S_CMP;
        end
        S_CMP: begin
          if (go_on) state <= S_SUB;
          else begin
            fin_q <= a_q;
            state <= S_IDLE;
          end
        end
        S_SUB: begin
          a_q   <= a_mux;
          state <= S_CMP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign done   = done_q;
  assign result = fin_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R2
  result_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (b_q == '0 || result <= b_q));

  // R8
  sub_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUB) |=> (a_q < $past(a_q)));

  // R5
  sub_to_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUB) |=> (state == S_CMP));

  // R7
  b_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy ? $stable(b_q) : 1'b1));

endmodule

// File: tb/test_subgt_loop.sv
module test_subgt_loop;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  subgt_loop #(.W(W)) i_subgt_loop (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .result(result)
  );

  function automatic int ref_res(int a, int b);
    int x = a;
    if (b == 0) return a;
    while (x > b) x = x - b;
    return x;
  endfunction

  function automatic int ref_k(int a, int b);
    int x = a;
    int k = 0;
    if (b == 0) return 0;
    while (x > b) begin x = x - b; k++; end
    return k;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inject: cycle index at which a bogus start is driven (-1 for none)
  task automatic run(string req, int a, int b, int inject);
    int n = 0;
    int k = ref_k(a, b);
    int busy_bad = 0;
    @(negedge clk);
    start = 1'b1; a_in = W'(a); b_in = W'(b);
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 2000) begin
      if (!busy) busy_bad++;
      if (n == inject) begin
        start = 1'b1; a_in = W'(a ^ 8'h5a); b_in = W'(1);
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check({req, " result"}, int'(result), ref_res(a, b));
    check("R5 latency", n, 2 * k + 1);
    check("R5 busy during job", busy_bad, 0);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
    check("R6 result held", int'(result), ref_res(a, b));
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    rst_n = 1'b1;

    run("R3 equal", 37, 37, -1);
    run("R3 less", 5, 200, -1);
    run("R4 b zero", 99, 0, -1);
    run("R4 b zero a max", 255, 0, -1);
    run("R2 multiple gives b", 60, 12, -1);
    run("R2 remainder", 61, 12, -1);
    run("R2 long run", 255, 1, -1);
    run("R8 high a high b", 250, 130, -1);
    run("R8 high a low b", 200, 3, -1);
    run("R8 high b gt a", 120, 129, -1);
    run("R7 start while busy", 100, 7, 3);
    run("R7 start while busy late", 90, 4, 20);

    for (int i = 0; i < 200; i++) begin
      int a = int'($urandom_range(0, 255));
      int b = int'($urandom_range(0, 255));
      if (i % 4 == 0) b = int'($urandom_range(1, 15));
      run("R2 random", a, b, (i % 5 == 0) ? 1 : -1);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule